// File: doc/BRIEF.md
# Audio Transmit Register and Interrupt Unit

This block is the control side of a serial audio transmitter. A host reaches it over a simple 32-bit register bus with word-aligned byte addresses. It holds a configuration word, an interrupt mask and a sticky interrupt status. It also owns the write side of the transmit sample queue, which holds 32-bit words. A stereo frame takes two words, left before right. The serializer drains the queue through a pop port at the head and receives the configuration fields on dedicated outputs.

Two conditions come from the queue occupancy. The first is an underrun, when the queue is empty. The second is a low-water condition, when occupancy falls below a threshold of the queue depth shifted right by the programmed trigger level. Each condition sets its status bit. The host clears a bit by writing 1 to it. One interrupt line is raised when interrupts are globally enabled and a set status bit is unmasked.

Top module: `aud_tx_regif`

## Requirements
- R1: After reset the configuration reads 0, the mask reads 0, the status reads 0, the queue is empty (`fifo_empty_o`=1) and `irq_o` is low.
- R2: Index 0 (byte address 0x00) reads the parameter `VERSION`. Writes to it have no effect.
- R3: Index 1 (0x04) is the configuration. Bit 0 is transmit enable, bit 1 is interrupt enable, bit 2 is left-first, bits 15:8 are the ratio, bits 21:16 the resolution, bits 27:24 the trigger level and bits 31:28 the channel field. Bits 7:3 and 23:22 read 0. Each field appears on its output port.
- R4: A configuration write with trigger level 15 stores level 14.
- R5: Index 2 (0x08) is the mask. Only bits 1:0 are writable and the other bits read 0.
- R6: A write to any of indexes 4 to 7 (0x10, 0x14, 0x18, 0x1C) appends one word to the queue. `fifo_word_o` shows the oldest word, and a pop removes it in arrival order. A pop on an empty queue has no effect.
- R7: A data write while the queue holds `DEPTH` words is dropped. Occupancy and the stored words are unchanged.
- R8: Reads of indexes 4 to 7 return 0.
- R9: Status bit 0 (underrun) is set on any clock edge at which the queue is empty, unless a status write clears it in that cycle.
- R10: Status bit 1 (low-water) is set on any clock edge at which occupancy is less than `DEPTH >> level`, unless a status write clears it in that cycle.
- R11: Index 3 (0x0C) is the status. Writing 1 to a bit clears it at that edge and writing 0 leaves it unchanged. A cleared bit sets again on the following edge if its condition still holds, and a set bit stays set after its condition goes away.
- R12: `irq_o` = config bit 1 AND (status AND mask) nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte address, bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |
| fifo_pop_i | input | 1 | Serializer removes the head word |
| fifo_word_o | output | 32 | Head word of the queue |
| fifo_empty_o | output | 1 | Queue holds no word |
| tx_en_o | output | 1 | Transmit enable field |
| left_first_o | output | 1 | Left-channel control field |
| ratio_o | output | 8 | Clock ratio field |
| res_o | output | 6 | Sample resolution field |
| trig_o | output | 4 | Trigger level field |
| chan_o | output | 4 | Channel field |

## Verification
The hardest situation to reach is a status bit that stays set after its condition has gone away, combined with a clear that hits only one bit. The bench first fills the queue to full so that both conditions are false and clears the status. It then pops the queue below the low-water mark so that only the level bit sets, and refills the queue. At that point the level bit must still read 1. A write of 1 to the other bit must leave it set, and only a write to the bit itself may clear it. The threshold compare is swept over every trigger level and every occupancy from empty to full, with mask and interrupt enable varied across the sweep.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned REG_ADDR_W = 5;
  localparam int unsigned IDX_W      = REG_ADDR_W - 2;

  // configuration word, most significant field first
  typedef struct packed {
    logic [3:0] chan;
    logic [3:0] trig;
    logic [1:0] rsv_hi;
    logic [5:0] res;
    logic [7:0] ratio;
    logic [4:0] rsv_lo;
    logic       left_first;
    logic       irq_en;
    logic       tx_en;
  } cfg_t;

  localparam logic [DATA_W-1:0] CFG_WMASK = 32'hFF3F_FF07;
  localparam logic [3:0]        TRIG_TOP  = 4'd14;

  localparam int unsigned NSRC     = 2;
  localparam int unsigned SRC_UNDR = 0;
  localparam int unsigned SRC_LOW  = 1;

  localparam logic [IDX_W-1:0] IDX_VER  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CFG  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MASK = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd3;

endpackage

// File: rtl/aud_tx_fifo.sv
`timescale 1ns/1ps
module aud_tx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             empty_o
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             full, push_ok, pop_ok;

  always_comb begin
    full     = (occ_q == FULL_C);
    push_ok  = push_i & ~full;
    pop_ok   = pop_i & (occ_q != '0);
    wr_ptr_d = push_ok ? wr_ptr_q + PTR_W'(1) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
    case ({push_ok, pop_ok})
      2'b10:   occ_d = occ_q + CNT_W'(1);
      2'b01:   occ_d = occ_q - CNT_W'(1);
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  // storage carries no reset; each slot has its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok & (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem[g] <= data_i;
    end
  end

  assign head_o  = mem[rd_ptr_q];
  assign occ_o   = occ_q;
  assign empty_o = (occ_q == '0);

endmodule

// File: rtl/aud_tx_cond.sv
`timescale 1ns/1ps
module aud_tx_cond
  import aud_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] occ_i,
  input  logic [3:0]       trig_i,
  output logic [NSRC-1:0]  cond_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] thresh;

  always_comb begin
    thresh           = DEPTH_C >> trig_i;
    cond_o           = '0;
    cond_o[SRC_UNDR] = (occ_i == '0);
    cond_o[SRC_LOW]  = (occ_i < thresh);
  end

endmodule

// File: rtl/aud_tx_regbank.sv
`timescale 1ns/1ps
module aud_tx_regbank
  import aud_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   cond_i,
  output cfg_t              cfg_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   stat_o,
  output logic              irq_o
);

  cfg_t            cfg_q, cfg_d, cfg_w;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] stat_q, stat_d;

  always_comb begin
    cfg_w = cfg_t'(wdata & CFG_WMASK);
    if (cfg_w.trig > TRIG_TOP) cfg_w.trig = TRIG_TOP;
    cfg_d  = cfg_we  ? cfg_w : cfg_q;
    mask_d = mask_we ? wdata[NSRC-1:0] : mask_q;
    for (int i = 0; i < NSRC; i++) begin
      stat_d[i] = (stat_we & wdata[i]) ? 1'b0 : (stat_q[i] | cond_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = cfg_q.irq_en & |(stat_q & mask_q);

endmodule

// File: rtl/aud_tx_regif.sv
`timescale 1ns/1ps
module aud_tx_regif
  import aud_tx_pkg::*;
#(
  parameter int unsigned       DEPTH   = 16,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0002,
  localparam int unsigned      CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq_o,
  input  logic                  fifo_pop_i,
  output logic [DATA_W-1:0]     fifo_word_o,
  output logic                  fifo_empty_o,
  output logic                  tx_en_o,
  output logic                  left_first_o,
  output logic [7:0]            ratio_o,
  output logic [5:0]            res_o,
  output logic [3:0]            trig_o,
  output logic [3:0]            chan_o
);

  logic [IDX_W-1:0] idx;
  logic             is_data;
  logic             cfg_we, mask_we, stat_we, push;
  cfg_t             cfg_w;
  logic [NSRC-1:0]  mask_w, stat_w, cond_w;
  logic [CNT_W-1:0] occ_w;
  logic             unused_addr;

  assign idx         = bus_addr[REG_ADDR_W-1:2];
  assign is_data     = idx[IDX_W-1];
  assign unused_addr = ^bus_addr[1:0];

  always_comb begin
    cfg_we  = bus_wr & (idx == IDX_CFG);
    mask_we = bus_wr & (idx == IDX_MASK);
    stat_we = bus_wr & (idx == IDX_STAT);
    push    = bus_wr & is_data;
  end

  always_comb begin
    bus_rdata = '0;
    if (!is_data) begin
      case (idx)
        IDX_VER:  bus_rdata = VERSION;
        IDX_CFG:  bus_rdata = DATA_W'(cfg_w);
        IDX_MASK: bus_rdata = DATA_W'(mask_w);
        IDX_STAT: bus_rdata = DATA_W'(stat_w);
        default:  bus_rdata = '0;
      endcase
    end
  end

  aud_tx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (bus_wdata),
    .pop_i   (fifo_pop_i),
    .head_o  (fifo_word_o),
    .occ_o   (occ_w),
    .empty_o (fifo_empty_o)
  );

  aud_tx_cond #(.DEPTH(DEPTH)) u_cond (
    .occ_i  (occ_w),
    .trig_i (cfg_w.trig),
    .cond_o (cond_w)
  );

  aud_tx_regbank u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .mask_we (mask_we),
    .stat_we (stat_we),
    .wdata   (bus_wdata),
    .cond_i  (cond_w),
    .cfg_o   (cfg_w),
    .mask_o  (mask_w),
    .stat_o  (stat_w),
    .irq_o   (irq_o)
  );

  assign tx_en_o      = cfg_w.tx_en;
  assign left_first_o = cfg_w.left_first;
  assign ratio_o      = cfg_w.ratio;
  assign res_o        = cfg_w.res;
  assign trig_o       = cfg_w.trig;
  assign chan_o       = cfg_w.chan;

endmodule

// File: rtl/aud_tx_regif_chk.sv
`timescale 1ns/1ps
module aud_tx_regif_chk
  import aud_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  fifo_pop_i,
  input logic                  irq_o,
  input logic [3:0]            trig_o,
  input cfg_t                  cfg,
  input logic [NSRC-1:0]       mask,
  input logic [NSRC-1:0]       stat,
  input logic [CNT_W-1:0]      occ
);

  logic stat_wr, data_wr;
  assign stat_wr = bus_wr & (bus_addr[REG_ADDR_W-1:2] == IDX_STAT);
  assign data_wr = bus_wr & bus_addr[REG_ADDR_W-1];

  AST_LEVEL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o != 4'd15) else $error("level above limit"); // R4

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH)) else $error("occupancy overflow"); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && occ == CNT_W'(DEPTH) && !fifo_pop_i) |=> occ == CNT_W'(DEPTH))
    else $error("write accepted while full"); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && fifo_pop_i && !data_wr) |=> occ == '0)
    else $error("pop on empty changed occupancy"); // R6

  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !(stat_wr && bus_wdata[SRC_UNDR])) |=> stat[SRC_UNDR])
    else $error("underrun not flagged"); // R9

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[SRC_LOW]) |=> !stat[SRC_LOW])
    else $error("clear did not take"); // R11

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cfg.irq_en && (stat & mask) != '0))
    else $error("spurious interrupt"); // R12

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.irq_en && (stat & mask) != '0) |-> irq_o)
    else $error("missing interrupt"); // R12

endmodule

bind aud_tx_regif aud_tx_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .fifo_pop_i (fifo_pop_i),
  .irq_o      (irq_o),
  .trig_o     (trig_o),
  .cfg        (cfg_w),
  .mask       (mask_w),
  .stat       (stat_w),
  .occ        (occ_w)
);

// File: tb/aud_tx_regif_test.sv
`timescale 1ns/1ps
module aud_tx_regif_test;

  localparam int DEPTH = 16;
  localparam logic [31:0] VER = 32'h0001_0002;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fifo_pop_i, fifo_empty_o;
  logic [31:0] fifo_word_o;
  logic        tx_en_o, left_first_o;
  logic [7:0]  ratio_o;
  logic [5:0]  res_o;
  logic [3:0]  trig_o, chan_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  aud_tx_regif #(.DEPTH(DEPTH), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .fifo_pop_i(fifo_pop_i), .fifo_word_o(fifo_word_o),
    .fifo_empty_o(fifo_empty_o), .tx_en_o(tx_en_o),
    .left_first_o(left_first_o), .ratio_o(ratio_o), .res_o(res_o),
    .trig_o(trig_o), .chan_o(chan_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!fifo_empty_o) begin
      fifo_pop_i = 1'b1;
      @(negedge clk);
    end
    fifo_pop_i = 1'b0;
  endtask

  task automatic push(input int k, input logic [31:0] d);
    wr(5'h10 + 5'(4 * (k % 4)), d);
  endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    @(negedge clk);
    #1 chk(req, fifo_word_o, exp);
    fifo_pop_i = 1'b1;
    @(negedge clk);
    fifo_pop_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; fifo_pop_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(5'h04, v); chk("R1 cfg", v, 0);
    rd(5'h08, v); chk("R1 mask", v, 0);
    rd(5'h0C, v); chk("R1 stat", v, 0);
    chk("R1 empty", 32'(fifo_empty_o), 1);
    chk("R1 irq", 32'(irq_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 version read-only
    rd(5'h00, v); chk("R2 version", v, VER);
    wr(5'h00, 32'hDEAD_BEEF);
    rd(5'h00, v); chk("R2 version after write", v, VER);

    // R3 / R4 config fields, reserved bits, clamp
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R3 R4 cfg all ones", v, 32'hFE3F_FF07);
    chk("R4 trig_o", 32'(trig_o), 14);
    chk("R3 outputs", {tx_en_o, left_first_o, ratio_o, res_o, chan_o},
        {1'b1, 1'b1, 8'hFF, 6'h3F, 4'hF});
    wr(5'h04, 32'h3B2A_5C06);
    rd(5'h04, v); chk("R3 cfg pattern", v, 32'h3B2A_5C06);
    chk("R3 outputs pattern", {tx_en_o, left_first_o, ratio_o, res_o, trig_o, chan_o},
        {1'b0, 1'b1, 8'h5C, 6'h2A, 4'hB, 4'h3});

    // R5 mask width
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R5 mask", v, 3);

    // R8 data addresses read zero
    for (int a = 4; a < 8; a++) begin
      rd(5'(4 * a), v); chk("R8 data read", v, 0);
    end

    // R6 order across all four data addresses, pop on empty ignored
    drain();
    fifo_pop_i = 1'b1; @(negedge clk); fifo_pop_i = 1'b0;
    chk("R6 empty after idle pop", 32'(fifo_empty_o), 1);
    for (int k = 0; k < 5; k++) push(k, 32'hA000_0000 + 32'(k * 7));
    for (int k = 0; k < 5; k++) pop_chk("R6 order", 32'hA000_0000 + 32'(k * 7));
    chk("R6 drained", 32'(fifo_empty_o), 1);

    // R7 overflow drop
    for (int k = 0; k <= DEPTH; k++) push(k, 32'h0000_0100 + 32'(k));
    for (int k = 0; k < DEPTH; k++) pop_chk("R7 contents", 32'h0000_0100 + 32'(k));
    chk("R7 extra word dropped", 32'(fifo_empty_o), 1);

    // R9 R10 R12 sweep of every level and occupancy
    for (int lv = 0; lv < 15; lv++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        logic [1:0] m, es;
        logic ie, ei;
        int thr;
        m   = 2'((n + lv) % 4);
        ie  = (lv % 3) != 2;
        thr = DEPTH >> lv;
        wr(5'h04, {4'h0, 4'(lv), 22'h0, ie, 1'b0});
        wr(5'h08, {30'h0, m});
        drain();
        for (int k = 0; k < n; k++) push(k, 32'(k));
        wr(5'h0C, 32'h3);
        @(negedge clk);
        es = {(n < thr), (n == 0)};
        rd(5'h0C, v); chk("R9 R10 status sweep", v, {30'h0, es});
        ei = ie & |(es & m);
        chk("R12 irq sweep", 32'(irq_o), 32'(ei));
      end
    end

    // R11 sticky bits and per-bit clear
    wr(5'h04, 32'h0100_0002);  // level 1, threshold 8, interrupts on
    wr(5'h08, 32'h3);
    drain();
    for (int k = 0; k < DEPTH; k++) push(k, 32'(k));
    wr(5'h0C, 32'h3);
    @(negedge clk);
    rd(5'h0C, v); chk("R11 cleared while full", v, 0);
    chk("R12 irq low", 32'(irq_o), 0);
    for (int k = 0; k < 9; k++) pop_chk("R11 pop", 32'(k));
    for (int k = 0; k < 9; k++) push(k, 32'h55);
    rd(5'h0C, v); chk("R11 level bit sticky", v, 2);
    chk("R12 irq high", 32'(irq_o), 1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); chk("R11 other bit clear keeps level", v, 2);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); chk("R11 zero write no effect", v, 2);
    wr(5'h0C, 32'h2);
    rd(5'h0C, v); chk("R11 level cleared", v, 0);
    wr(5'h04, 32'h0100_0000);
    wr(5'h0C, 32'h0);
    drain();
    @(negedge clk);
    rd(5'h0C, v); chk("R11 R9 resets after drain", v, 3);
    chk("R12 irq gated by enable", 32'(irq_o), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule